// File: doc/BRIEF.md
# Non-IQ Sampling Demodulator

This block recovers the in-phase and quadrature baseband components of an intermediate-frequency tone. The tone is digitised by a converter whose clock runs at N/M times the tone frequency, with N and M integers. Each new sample therefore lands at a fixed phase step of 2π·M/N further along the carrier. Over N samples, one full constellation, the sample positions cover every phase point once.

A stream of signed converter samples arrives with a valid strobe. Each accepted sample is weighted by a sine and a cosine coefficient, chosen by the sample's position in the constellation, and the two products are added to separate running sums. When the last position of the constellation is accepted, both sums are scaled by 2/N, clipped to the output width and registered. A one-cycle valid pulse marks each new I/Q pair. The sums are then cleared for the next constellation. The coefficient table is built when the design is elaborated, so any N/M ratio is supported without a quarter-cycle pattern.

Top module: `niq_demod`

## Requirements
- R1: While reset is high, and on the first cycle after it, `iq_vld` is 0 and `i_out` and `q_out` are 0.
- R2: A sample is taken only in a cycle where `smp_vld` is 1. Data presented while `smp_vld` is 0 does not change any result, and idle cycles between samples do not change any result.
- R3: `iq_vld` is high for exactly one cycle. That cycle is the one right after the clock edge that takes the N-th sample of a constellation. It is never high in two successive cycles.
- R4: I is built from the sums S_I = Σ y_i·ws_i, where y_i is the i-th accepted sample in the constellation (i from 0 to N-1) and ws_i = floor((2^(WW-1)-1)·sin(2π·M·i/N) + 0.5).
- R5: Q is built in the same way from S_Q = Σ y_i·wc_i, where wc_i = floor((2^(WW-1)-1)·cos(2π·M·i/N) + 0.5).
- R6: Each output equals (S·K) arithmetically shifted right by SH+WW-1 bits, with K = floor((2^(SH+1) + N/2)/N). This gives the 2/N scaling.
- R7: A scaled value above 2^(OW-1)-1 is output as 2^(OW-1)-1. A scaled value below -2^(OW-1) is output as -2^(OW-1).
- R8: Each constellation's result depends only on its own N samples. The sums restart from zero after every output.
- R9: A reset in the middle of a constellation discards the partial sums and the position. The first output after reset covers N new samples.
- R10: `i_out` and `q_out` keep their value from one `iq_vld` pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DW | Signed converter sample |
| i_out | output | OW | Signed in-phase result |
| q_out | output | OW | Signed quadrature result |
| iq_vld | output | 1 | One-cycle pulse marking a new I/Q pair |

## Verification
The hardest case to reach is a constellation whose samples are spread out by idle cycles. During those idle cycles the data bus carries large junk values. The bench therefore plays the same N samples once back to back and once with gaps of varying length filled with junk, and both runs must give the same pair. Saturation is reached by running the bench instance with a narrow output width. Its input signs follow the sine weights, so the correlated sum exceeds full scale in both directions. A reset is also applied after a partial constellation, followed by a full one.

// File: rtl/niq_pkg.sv
package niq_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded weight of amplitude (2^wf - 1) at position idx of an n-point
    // constellation stepping m carrier cycles per n samples.
    function automatic int niq_weight(input int n, input int m, input int idx,
                                      input int wf, input bit use_cos);
        real ang;
        real amp;
        real v;
        ang = TWO_PI * real'(m) * real'(idx) / real'(n);
        amp = real'((1 << wf) - 1);
        v   = use_cos ? $cos(ang) : $sin(ang);
        return $rtoi($floor(amp * v + 0.5));
    endfunction

endpackage

// File: rtl/niq_weight_rom.sv
module niq_weight_rom #(
    parameter int N  = 10,
    parameter int M  = 3,
    parameter int WW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0]        idx,
    output logic signed [WW-1:0] sin_w,
    output logic signed [WW-1:0] cos_w
);
    import niq_pkg::*;

    logic signed [WW-1:0] sin_tbl [N];
    logic signed [WW-1:0] cos_tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_tbl
        localparam int SV = niq_weight(N, M, g, WW - 1, 1'b0);
        localparam int CV = niq_weight(N, M, g, WW - 1, 1'b1);
        assign sin_tbl[g] = WW'(SV);
        assign cos_tbl[g] = WW'(CV);
    end

    assign sin_w = sin_tbl[idx];
    assign cos_w = cos_tbl[idx];

endmodule

// File: rtl/niq_scale.sv
module niq_scale #(
    parameter int N    = 10,
    parameter int SUMW = 33,
    parameter int WW   = 16,
    parameter int SH   = 16,
    parameter int OW   = 16
) (
    input  logic signed [SUMW-1:0] sum_in,
    output logic signed [OW-1:0]   res_out
);
    localparam int PW   = SUMW + SH + 3;
    localparam int SHT  = SH + WW - 1;
    localparam longint KV = ((longint'(1) << (SH + 1)) + longint'(N / 2)) / longint'(N);
    localparam logic signed [PW-1:0] KSC  = PW'(KV);
    localparam logic signed [PW-1:0] MAXP = PW'((longint'(1) << (OW - 1)) - 1);
    localparam logic signed [PW-1:0] MINP = PW'(-(longint'(1) << (OW - 1)));

    logic signed [PW-1:0] prod_w;
    logic signed [PW-1:0] shd_w;

    always_comb begin
        prod_w = PW'(sum_in) * KSC;
        shd_w  = prod_w >>> SHT;
        if (shd_w > MAXP) begin
            res_out = OW'(MAXP);
        end else if (shd_w < MINP) begin
            res_out = OW'(MINP);
        end else begin
            res_out = OW'(shd_w);
        end
    end

endmodule

// File: rtl/niq_demod.sv
module niq_demod #(
    parameter int N  = 10,
    parameter int M  = 3,
    parameter int DW = 12,
    parameter int WW = 16,
    parameter int OW = 16,
    parameter int SH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_data,
    output logic signed [OW-1:0] i_out,
    output logic signed [OW-1:0] q_out,
    output logic                 iq_vld
);
    localparam int IW   = (N > 1) ? $clog2(N) : 1;
    localparam int PRW  = DW + WW;
    localparam int SUMW = PRW + IW + 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef struct packed {
        logic [IW-1:0]          idx;
        logic signed [SUMW-1:0] acc_i;
        logic signed [SUMW-1:0] acc_q;
        logic signed [OW-1:0]   i_res;
        logic signed [OW-1:0]   q_res;
        logic                   vld;
    } state_t;

    state_t st_q, st_d;

    logic signed [WW-1:0]   sin_w, cos_w;
    logic signed [PRW-1:0]  prod_i, prod_q;
    logic signed [SUMW-1:0] sum_i, sum_q;
    logic signed [OW-1:0]   scl_i, scl_q;

    niq_weight_rom #(.N(N), .M(M), .WW(WW)) u_rom (
        .idx   (st_q.idx),
        .sin_w (sin_w),
        .cos_w (cos_w)
    );

    assign prod_i = PRW'(smp_data) * PRW'(sin_w);
    assign prod_q = PRW'(smp_data) * PRW'(cos_w);
    assign sum_i  = st_q.acc_i + SUMW'(prod_i);
    assign sum_q  = st_q.acc_q + SUMW'(prod_q);

    niq_scale #(.N(N), .SUMW(SUMW), .WW(WW), .SH(SH), .OW(OW)) u_scl_i (
        .sum_in  (sum_i),
        .res_out (scl_i)
    );

    niq_scale #(.N(N), .SUMW(SUMW), .WW(WW), .SH(SH), .OW(OW)) u_scl_q (
        .sum_in  (sum_q),
        .res_out (scl_q)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (smp_vld) begin
            if (st_q.idx == LAST) begin
                st_d.idx   = '0;
                st_d.acc_i = '0;
                st_d.acc_q = '0;
                st_d.i_res = scl_i;
                st_d.q_res = scl_q;
                st_d.vld   = 1'b1;
            end else begin
                st_d.idx   = st_q.idx + 1'b1;
                st_d.acc_i = sum_i;
                st_d.acc_q = sum_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_out  = st_q.i_res;
    assign q_out  = st_q.q_res;
    assign iq_vld = st_q.vld;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.idx <= LAST); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(st_q.idx)); // R2
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        iq_vld |=> !iq_vld); // R3
    AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(iq_vld) |-> $past(smp_vld)); // R3
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && st_q.idx == LAST) |=> (st_q.acc_i == '0 && st_q.acc_q == '0)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !iq_vld |=> ($stable(i_out) && $stable(q_out)) || iq_vld); // R10

endmodule

// File: tb/sim_niq_demod.sv
module sim_niq_demod;
    localparam int  N  = 10;
    localparam int  M  = 3;
    localparam int  DW = 12;
    localparam int  WW = 16;
    localparam int  OW = 12;
    localparam int  SH = 16;
    localparam time TCLK = 10ns;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_vld = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic signed [OW-1:0] i_out, q_out;
    logic                 iq_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(TCLK / 2) clk = ~clk;

    niq_demod #(.N(N), .M(M), .DW(DW), .WW(WW), .OW(OW), .SH(SH)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .i_out(i_out), .q_out(q_out), .iq_vld(iq_vld)
    );

    function automatic longint wgt(input int i, input bit c);
        real a;
        real v;
        a = 6.283185307179586 * real'(M) * real'(i) / real'(N);
        v = c ? $cos(a) : $sin(a);
        return longint'($rtoi($floor(real'((1 << (WW - 1)) - 1) * v + 0.5)));
    endfunction

    function automatic int expect_val(input int ys[N], input bit c);
        longint s;
        longint k;
        longint r;
        longint mx;
        s = 0;
        for (int i = 0; i < N; i++) s += longint'(ys[i]) * wgt(i, c);
        k  = ((longint'(1) << (SH + 1)) + longint'(N / 2)) / longint'(N);
        r  = (s * k) >>> (SH + WW - 1);
        mx = (longint'(1) << (OW - 1)) - 1;
        if (r > mx) r = mx;
        if (r < -mx - 1) r = -mx - 1;
        return int'(r);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Feed one constellation; gap>0 inserts idle cycles with junk data.
    task automatic feed(input int ys[N], input int gap);
        for (int k = 0; k < N; k++) begin
            for (int g = 0; g < ((gap > 0) ? (gap + (k % 3)) : 0); g++) begin
                @(negedge clk);
                smp_vld  = 1'b0;
                smp_data = (g % 2 == 0) ? 12'sh7FF : -12'sh800;
                chk("R3 no pulse mid-constellation", int'(iq_vld), 0);
            end
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = DW'(ys[k]);
        end
        @(negedge clk);
        smp_vld  = 1'b0;
        smp_data = -12'sh555;
    endtask

    task automatic check_result(input string tag, input int ys[N]);
        chk({tag, " R3 pulse"}, int'(iq_vld), 1);
        chk({tag, " R4 I"}, int'(i_out), expect_val(ys, 1'b0));
        chk({tag, " R5 Q"}, int'(q_out), expect_val(ys, 1'b1));
        @(negedge clk);
        chk({tag, " R3 single cycle"}, int'(iq_vld), 0);
    endtask

    function automatic void tone(output int ys[N], input real amp, input real ph);
        for (int i = 0; i < N; i++)
            ys[i] = $rtoi($floor(amp * $sin(6.283185307179586 * real'(M) * real'(i) / real'(N) + ph) + 0.5));
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", int'(iq_vld), 0);
        chk("R1 i in reset", int'(i_out), 0);
        chk("R1 q in reset", int'(q_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld after reset", int'(iq_vld), 0);
        chk("R1 i after reset", int'(i_out), 0);
    endtask

    task automatic t_tone();
        int ys[N];
        tone(ys, 1500.0, 0.4);
        feed(ys, 0);
        check_result("tone R6", ys);
        tone(ys, 900.0, 2.1);
        feed(ys, 0);
        check_result("tone2 R6", ys);
    endtask

    task automatic t_gaps();
        int ys[N];
        tone(ys, 1200.0, -1.0);
        feed(ys, 2);
        check_result("gapped R2", ys);
    endtask

    task automatic t_sat();
        int ys[N];
        for (int i = 0; i < N; i++) ys[i] = (wgt(i, 1'b0) >= 0) ? 2047 : -2048;
        feed(ys, 0);
        chk("R7 positive clip", int'(i_out), 2047);
        check_result("sat R7", ys);
        for (int i = 0; i < N; i++) ys[i] = (wgt(i, 1'b0) >= 0) ? -2048 : 2047;
        feed(ys, 0);
        chk("R7 negative clip", int'(i_out), -2048);
        check_result("satneg R7", ys);
    endtask

    task automatic t_independent();
        int a[N];
        int b[N];
        int ia;
        tone(a, 1800.0, 0.0);
        tone(b, 300.0, 1.3);
        feed(a, 0);
        ia = int'(i_out);
        check_result("first R8", a);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = DW'(b[k]);
        end
        @(negedge clk);
        smp_vld = 1'b0;
        chk("R10 i held", int'(i_out), ia);
        chk("R10 no pulse", int'(iq_vld), 0);
        for (int k = 5; k < N; k++) begin
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = DW'(b[k]);
        end
        @(negedge clk);
        smp_vld = 1'b0;
        check_result("second R8", b);
    endtask

    task automatic t_mid_reset();
        int ys[N];
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            smp_vld  = 1'b1;
            smp_data = 12'sh600;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        rst     = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 outputs cleared", int'(i_out), 0);
        tone(ys, 1000.0, 0.7);
        feed(ys, 1);
        check_result("restart R9", ys);
    endtask

    initial begin
        t_reset();
        t_tone();
        t_gaps();
        t_sat();
        t_independent();
        t_mid_reset();
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule